// File: doc/BRIEF.md
# Registered Small-Table Register File

This block is a small synchronous storage table with one write port and one or two read ports; a parameter sets how many read ports there are. Each port is fully registered. The write address and write data, together with every read address, enter input registers before they reach the storage core. Every read result leaves through an output register. The surrounding logic therefore sees only flop-to-flop paths, whatever the internal timing of the core.

The core is built as one row of storage cells for each bit of the stored word. A captured address selects one column, which spans all rows. Each stored word carries one extra bit, the even-parity bit supplied by the writer. Parity can be checked at two points, and each check can be switched on or off by its own parameter. The first point is the word entering the table. The second is the word leaving it. Each check drives a registered error flag.

Elaboration stops with an error if the table holds fewer than 48 or more than 2112 data bits, or if the read-port count is anything other than one or two.

Top module: `lat_regfile`

## Requirements
- R1: When `wr_en` is high, the word on `wr_data` and the bit on `wr_par` are stored at `wr_addr`. A read of that address presented one cycle later, or any cycle after that, returns them.
- R2: A read address presented before rising edge N appears as data on the matching read outputs after rising edge N+1. After edge N alone, the outputs still show the previous result.
- R3: The read outputs keep their value for as long as the read address stays unchanged and no write occurs.
- R4: If a read and a write are presented to the same address in the same cycle, the read returns the old contents. A read of that address presented in the next cycle returns the new word.
- R5: With `RD_PORTS`=2, the two read ports are independent, each with its own address. With `RD_PORTS`=1, `rd1_data`, `rd1_par` and `rd1_perr` stay 0.
- R6: Parity is even: a valid word has an even number of ones across `{wr_par, wr_data}`. With input checking enabled, `wr_perr` is high for exactly the cycle after a write with an odd count is presented. In every other cycle it is low.
- R7: The stored parity bit is returned on `rdN_par` together with its data. A word written with wrong parity is still stored exactly as it was given.
- R8: With output checking enabled, `rdN_perr` is high in the same cycle as an `rdN_data`/`rdN_par` pair that has an odd number of ones. Otherwise it is low.
- R9: When a check is disabled by its parameter (`IN_CHK`=0 or `OUT_CHK`=0), the matching error flags stay low, even for words with bad parity.
- R10: While `rst` is high at a rising edge, all port registers are cleared: read outputs, parity outputs and error flags read 0. The stored contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | DATA_W | Write data |
| wr_par | input | 1 | Even-parity bit of the write data |
| rd0_addr | input | AW | Read port 0 address |
| rd1_addr | input | AW | Read port 1 address (unused with one port) |
| wr_perr | output | 1 | Input parity error flag |
| rd0_data | output | DATA_W | Read port 0 data |
| rd0_par | output | 1 | Read port 0 stored parity bit |
| rd0_perr | output | 1 | Read port 0 output parity error flag |
| rd1_data | output | DATA_W | Read port 1 data |
| rd1_par | output | 1 | Read port 1 stored parity bit |
| rd1_perr | output | 1 | Read port 1 output parity error flag |

## Verification
The output parity check is the hardest case to trigger, because correct writers never store a bad word. The stimulus writes a word on purpose with the wrong parity bit. It confirms that the input flag fires for that write, then reads the word back and expects the output flag to fire alongside the unchanged corrupt word. A second instance, with one read port, both checks disabled and the minimum size of 48 bits, sees the same traffic and must keep every flag low. The read-during-write collision is set up by presenting the same address on the write port and on read port 0 in one cycle, with read port 1 taking that address one cycle later. A reset is then applied in the middle of the run to show that the table contents survive it.

// File: rtl/lat_rf_pkg.sv
package lat_rf_pkg;

   localparam int MIN_BITS = 48;
   localparam int MAX_BITS = 2112;

   function automatic int addr_bits(input int depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/lat_rf_par_chk.sv
module lat_rf_par_chk #(
   parameter int W  = 9,
   parameter bit EN = 1'b1
) (
   input  logic [W-1:0] word,
   input  logic         valid,
   output logic         err
);
   if (EN) begin : g_on
      assign err = valid & (^word);
   end else begin : g_off
      logic unused_in;
      assign unused_in = valid ^ (^word);
      assign err       = 1'b0;
   end
endmodule

// File: rtl/lat_rf_col_decode.sv
module lat_rf_col_decode #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic             en,
   input  logic [AW-1:0]    addr,
   output logic [DEPTH-1:0] sel
);
   always_comb begin
      sel = '0;
      for (int c = 0; c < DEPTH; c++) begin
         sel[c] = en && (addr == AW'(c));
      end
   end
endmodule

// File: rtl/lat_rf_bit_row.sv
module lat_rf_bit_row #(
   parameter int DEPTH = 16,
   parameter int NRD   = 2,
   parameter int AW    = 4
) (
   input  logic                    clk,
   input  logic [DEPTH-1:0]        col_sel,
   input  logic                    wbit,
   input  logic [NRD-1:0][AW-1:0]  raddr,
   output logic [NRD-1:0]          rbit
);
   logic [DEPTH-1:0] cells;

   always_ff @(posedge clk) begin
      for (int c = 0; c < DEPTH; c++) begin
         if (col_sel[c]) cells[c] <= wbit;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      if (DEPTH == (1 << AW)) begin : g_full
         assign rbit[p] = cells[raddr[p]];
      end else begin : g_part
         assign rbit[p] = (32'(raddr[p]) < DEPTH) ? cells[raddr[p]] : 1'b0;
      end
   end
endmodule

// File: rtl/lat_rf_rd_port.sv
module lat_rf_rd_port #(
   parameter int DATA_W  = 8,
   parameter int AW      = 4,
   parameter bit OUT_CHK = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [AW-1:0]     addr_in,
   output logic [AW-1:0]     addr_q,
   input  logic [DATA_W:0]   word_in,
   output logic [DATA_W-1:0] data_q,
   output logic              par_q,
   output logic              perr_q
);
   logic bad;

   lat_rf_par_chk #(.W(DATA_W + 1), .EN(OUT_CHK)) u_out_chk (
      .word  (word_in),
      .valid (1'b1),
      .err   (bad)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         data_q <= '0;
         par_q  <= 1'b0;
         perr_q <= 1'b0;
      end else begin
         addr_q <= addr_in;
         data_q <= word_in[DATA_W-1:0];
         par_q  <= word_in[DATA_W];
         perr_q <= bad;
      end
   end
endmodule

// File: rtl/lat_regfile.sv
module lat_regfile
   import lat_rf_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 16,
   parameter int RD_PORTS = 2,
   parameter bit IN_CHK   = 1'b1,
   parameter bit OUT_CHK  = 1'b1,
   localparam int AW      = addr_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_par,
   input  logic [AW-1:0]     rd0_addr,
   input  logic [AW-1:0]     rd1_addr,
   output logic              wr_perr,
   output logic [DATA_W-1:0] rd0_data,
   output logic              rd0_par,
   output logic              rd0_perr,
   output logic [DATA_W-1:0] rd1_data,
   output logic              rd1_par,
   output logic              rd1_perr
);
   localparam int WORD_W     = DATA_W + 1;
   localparam int TOTAL_BITS = DATA_W * DEPTH;

   if (TOTAL_BITS < MIN_BITS || TOTAL_BITS > MAX_BITS) begin : g_bad_size
      $error("lat_regfile: DATA_W*DEPTH outside supported range");
   end
   if (RD_PORTS < 1 || RD_PORTS > 2) begin : g_bad_ports
      $error("lat_regfile: RD_PORTS must be 1 or 2");
   end

   // write side: input registers and entry check
   logic              we_q;
   logic [AW-1:0]     wa_q;
   logic [WORD_W-1:0] wd_q;
   logic              wperr_q;
   logic              in_bad;
   logic [DEPTH-1:0]  col_sel;

   lat_rf_par_chk #(.W(WORD_W), .EN(IN_CHK)) u_in_chk (
      .word  ({wr_par, wr_data}),
      .valid (wr_en),
      .err   (in_bad)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         we_q    <= 1'b0;
         wa_q    <= '0;
         wd_q    <= '0;
         wperr_q <= 1'b0;
      end else begin
         we_q    <= wr_en;
         wa_q    <= wr_addr;
         wd_q    <= {wr_par, wr_data};
         wperr_q <= in_bad;
      end
   end

   assign wr_perr = wperr_q;

   lat_rf_col_decode #(.DEPTH(DEPTH), .AW(AW)) u_dec (
      .en   (we_q),
      .addr (wa_q),
      .sel  (col_sel)
   );

   // storage core: one row per word bit
   logic [RD_PORTS-1:0][AW-1:0]     ra_core;
   logic [WORD_W-1:0][RD_PORTS-1:0] row_out;
   logic [RD_PORTS-1:0][WORD_W-1:0] core_word;

   for (genvar b = 0; b < WORD_W; b++) begin : g_row
      lat_rf_bit_row #(.DEPTH(DEPTH), .NRD(RD_PORTS), .AW(AW)) u_row (
         .clk     (clk),
         .col_sel (col_sel),
         .wbit    (wd_q[b]),
         .raddr   (ra_core),
         .rbit    (row_out[b])
      );
      for (genvar p = 0; p < RD_PORTS; p++) begin : g_tp
         assign core_word[p][b] = row_out[b][p];
      end
   end

   // read ports
   logic [1:0][AW-1:0]     ra_in;
   logic [1:0][DATA_W-1:0] rdo_data;
   logic [1:0]             rdo_par;
   logic [1:0]             rdo_perr;

   assign ra_in = {rd1_addr, rd0_addr};

   for (genvar p = 0; p < 2; p++) begin : g_port
      if (p < RD_PORTS) begin : g_live
         lat_rf_rd_port #(.DATA_W(DATA_W), .AW(AW), .OUT_CHK(OUT_CHK)) u_port (
            .clk     (clk),
            .rst     (rst),
            .addr_in (ra_in[p]),
            .addr_q  (ra_core[p]),
            .word_in (core_word[p]),
            .data_q  (rdo_data[p]),
            .par_q   (rdo_par[p]),
            .perr_q  (rdo_perr[p])
         );
      end else begin : g_idle
         logic unused_addr;
         assign unused_addr = ^ra_in[p];
         assign rdo_data[p] = '0;
         assign rdo_par[p]  = 1'b0;
         assign rdo_perr[p] = 1'b0;
      end
   end

   assign rd0_data = rdo_data[0];
   assign rd0_par  = rdo_par[0];
   assign rd0_perr = rdo_perr[0];
   assign rd1_data = rdo_data[1];
   assign rd1_par  = rdo_par[1];
   assign rd1_perr = rdo_perr[1];

endmodule

// File: rtl/lat_rf_chk.sv
module lat_rf_chk #(
   parameter int DATA_W   = 8,
   parameter int AW       = 4,
   parameter int RD_PORTS = 2,
   parameter bit IN_CHK   = 1'b1,
   parameter bit OUT_CHK  = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [AW-1:0]     wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_par,
   input logic [AW-1:0]     rd0_addr,
   input logic [AW-1:0]     rd1_addr,
   input logic              wr_perr,
   input logic [DATA_W-1:0] rd0_data,
   input logic              rd0_par,
   input logic              rd0_perr,
   input logic [DATA_W-1:0] rd1_data,
   input logic              rd1_par,
   input logic              rd1_perr
);
   logic rst_d;
   logic unused_sink;
   assign unused_sink = ^{wr_addr, rd1_addr, rd1_data, rd1_par, rd1_perr};

   always_ff @(posedge clk) rst_d <= rst;

   // R10: a reset edge leaves every port register cleared
   always_ff @(posedge clk) begin
      if (rst_d) begin
         a_r10_reset_clears: assert (rd0_data == '0 && !rd0_par && !rd0_perr &&
                                     !wr_perr && rd1_data == '0 && !rd1_perr);
      end
   end

   // R6: entry flag reflects the write seen one edge earlier
   a_r6_entry_flag: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (wr_perr == (IN_CHK && $past(wr_en) && (^$past({wr_par, wr_data})))));

   // R8 / R9: exit flag matches the registered word it accompanies
   a_r8_exit_flag0: assert property (@(posedge clk) disable iff (rst)
      rd0_perr == (OUT_CHK && (^{rd0_par, rd0_data})));

   if (RD_PORTS == 2) begin : g_p1
      a_r8_exit_flag1: assert property (@(posedge clk) disable iff (rst)
         rd1_perr == (OUT_CHK && (^{rd1_par, rd1_data})));
   end

   // R3: unchanged address and no write keep the output still
   a_r3_hold_rd0: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) &&
       $past(rd0_addr, 2) == $past(rd0_addr, 3) && !$past(wr_en, 3))
      |-> (rd0_data == $past(rd0_data) && rd0_par == $past(rd0_par)));

endmodule

bind lat_regfile lat_rf_chk #(
   .DATA_W(DATA_W), .AW(AW), .RD_PORTS(RD_PORTS), .IN_CHK(IN_CHK), .OUT_CHK(OUT_CHK)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .wr_par(wr_par), .rd0_addr(rd0_addr), .rd1_addr(rd1_addr), .wr_perr(wr_perr),
   .rd0_data(rd0_data), .rd0_par(rd0_par), .rd0_perr(rd0_perr),
   .rd1_data(rd1_data), .rd1_par(rd1_par), .rd1_perr(rd1_perr)
);

// File: tb/lat_regfile_tb_top.sv
module lat_regfile_tb_top;
   logic       clk = 1'b0;
   logic       rst;
   logic       wr_en, wr_par;
   logic [3:0] wr_addr, rd0_addr, rd1_addr;
   logic [7:0] wr_data;
   logic       wr_perr, rd0_par, rd0_perr, rd1_par, rd1_perr;
   logic [7:0] rd0_data, rd1_data;
   // small instance: one read port, checks off, 6x8 = 48 bits
   logic       wr_perr2, rd0_par2, rd0_perr2, rd1_par2, rd1_perr2;
   logic [5:0] rd0_data2, rd1_data2;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   logic [7:0] m  [16];
   logic [5:0] m2 [8];

   // {addr, data}: low three address bits all distinct
   localparam logic [11:0] WR_TAB [8] = '{12'h05A, 12'h9C3, 12'h217, 12'hBF0,
                                          12'h481, 12'hD6E, 12'h629, 12'hFB4};

   always #5 clk = ~clk;

   lat_regfile dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_par(wr_par), .rd0_addr(rd0_addr), .rd1_addr(rd1_addr), .wr_perr(wr_perr),
      .rd0_data(rd0_data), .rd0_par(rd0_par), .rd0_perr(rd0_perr),
      .rd1_data(rd1_data), .rd1_par(rd1_par), .rd1_perr(rd1_perr));

   lat_regfile #(.DATA_W(6), .DEPTH(8), .RD_PORTS(1), .IN_CHK(1'b0), .OUT_CHK(1'b0)) dut_small (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr[2:0]), .wr_data(wr_data[5:0]),
      .wr_par(wr_par), .rd0_addr(rd0_addr[2:0]), .rd1_addr(rd1_addr[2:0]), .wr_perr(wr_perr2),
      .rd0_data(rd0_data2), .rd0_par(rd0_par2), .rd0_perr(rd0_perr2),
      .rd1_data(rd1_data2), .rd1_par(rd1_par2), .rd1_perr(rd1_perr2));

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic p);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_par = p;
      tick();
      wr_en = 1'b0;
      m[a] = d;
      m2[a[2:0]] = d[5:0];
   endtask

   task automatic do_read(input logic [3:0] a0, input logic [3:0] a1);
      rd0_addr = a0; rd1_addr = a1;
      tick();
      tick();
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hung expected finish");
         report();
         $finish;
      end
   end

   initial begin
      logic [7:0] old;
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_par = 1'b0;
      rd0_addr = '0; rd1_addr = '0;
      @(negedge clk);
      repeat (5) tick();
      check("R10 reset rd0_data", rd0_data, 0);
      check("R10 reset flags", {wr_perr, rd0_perr, rd1_perr, rd0_par}, 0);
      rst = 1'b0;
      tick();

      // table walk: write all entries, then read back on both ports
      for (int i = 0; i < 8; i++) begin
         do_write(WR_TAB[i][11:8], WR_TAB[i][7:0], ^WR_TAB[i][7:0]);
      end
      for (int i = 0; i < 8; i++) begin
         logic [3:0] a0, a1;
         a0 = WR_TAB[i][11:8];
         a1 = WR_TAB[7-i][11:8];
         do_read(a0, a1);
         check("R1 R2 rd0 data", rd0_data, m[a0]);
         check("R5 rd1 data independent", rd1_data, m[a1]);
         check("R7 rd0 parity bit", rd0_par, ^m[a0]);
         check("R8 clean word no flag", {rd0_perr, rd1_perr}, 0);
         check("R5 small rd0 data", rd0_data2, m2[a0[2:0]]);
         check("R5 small rd1 idle", {rd1_data2, rd1_par2, rd1_perr2}, 0);
      end

      // R6: write with wrong parity (0x3C has even ones, parity bit 1)
      wr_en = 1'b1; wr_addr = 4'h5; wr_data = 8'h3C; wr_par = 1'b1;
      tick();
      check("R6 entry flag set", wr_perr, 1);
      check("R9 small entry flag off", wr_perr2, 0);
      wr_en = 1'b0;
      m[5] = 8'h3C; m2[5] = 6'h3C;
      tick();
      check("R6 entry flag one cycle", wr_perr, 0);

      // R7/R8: corrupt word read back unchanged, exit flag set
      do_read(4'h5, 4'hD);
      check("R7 corrupt data kept", rd0_data, 8'h3C);
      check("R7 corrupt parity kept", rd0_par, 1);
      check("R8 exit flag set", rd0_perr, 1);
      check("R8 other port clean", rd1_perr, 0);
      check("R9 small exit flag off", rd0_perr2, 0);

      // R3: hold address, no writes
      repeat (3) tick();
      check("R3 output held", rd0_data, 8'h3C);

      // R2: latency of two edges
      rd0_addr = 4'h0;
      tick();
      check("R2 not after one edge", rd0_data, 8'h3C);
      tick();
      check("R2 valid after two edges", rd0_data, m[0]);

      // R4: collision, old then new
      old = m[2];
      rd0_addr = 4'h2;
      wr_en = 1'b1; wr_addr = 4'h2; wr_data = 8'hA5; wr_par = ^8'hA5;
      tick();
      wr_en = 1'b0; rd1_addr = 4'h2;
      m[2] = 8'hA5; m2[2] = 6'h25;
      tick();
      check("R4 same cycle reads old", rd0_data, old);
      tick();
      check("R4 R1 next cycle reads new", rd1_data, 8'hA5);

      // R10: mid-run reset keeps contents
      rst = 1'b1;
      tick();
      tick();
      check("R10 reset clears data", {rd0_data, rd1_data}, 0);
      check("R10 reset clears flags", {wr_perr, rd0_perr, rd1_perr}, 0);
      rst = 1'b0;
      do_read(4'h6, 4'hF);
      check("R10 contents kept p0", rd0_data, m[6]);
      check("R10 contents kept p1", rd1_data, m[15]);

      done = 1'b1;
      report();
      $finish;
   end
endmodule